// File: doc/BRIEF.md
# No-FIFO Serial Port Register Model

This block is the byte-wide register set of a classic serial port that has no receive or transmit queue. A processor reaches it through a simple request/acknowledge port with a 3-bit address. It holds the data, interrupt enable, interrupt identification, line control, modem control, line status, modem status and scratch registers. Serial framing, baud generation and the divisor latch are not modelled. Characters arrive from a host-side valid/ready byte stream and leave on a second valid/ready byte stream. A single interrupt request line reports pending causes.

Only one received byte can be held. While it sits in the data register, the receive stream is back-pressured. The next byte is taken only once the processor has read the held one. Transmission is treated as instantaneous: a data write places the byte on the transmit stream, and the write is acknowledged in the cycle that the stream accepts it. The identification register works as a set of cause bits. Bit 0 is the active-low "pending" flag, derived from the other bits. A few registers report fixed or altered values so that the port looks like an early part: line status always shows the transmitter idle, modem status always shows the carrier, data-set-ready and clear-to-send lines active, and the scratch register reads back inverted.

Top module: `serial_regfile`

## Requirements
- R1: After reset the identification register is 0x01, every other stored register and the held byte are 0, `irq` is low, `rx_ready` is high and `tx_valid` is low.
- R2: `irq` is high exactly when bit 0 of the identification register is 0.
- R3: A byte accepted on the receive stream is written to the data register and sets line status bit 0. If interrupt-enable bit 0 is 1, it also sets identification bit 2 and clears identification bit 0.
- R4: While line status bit 0 is set, `rx_ready` stays low. The held byte does not change, and an offered byte is taken only after the processor reads address 0.
- R5: A write to address 0 drives the byte on `tx_data` with `tx_valid`. `cpu_ack` does not rise until the transmit stream accepts it. If interrupt-enable bit 1 is 1, the transfer sets identification bit 1 and clears bit 0.
- R6: A read of address 0 returns the held byte, then zeroes it and clears line status bit 0. With no byte held, it returns the current (zero) value with `cpu_rd_err` high. Either way it clears identification bit 2.
- R7: A read of address 2 returns the identification register, then clears its bit 1.
- R8: If a read of address 0 or 2 leaves the identification register at 0x00, it becomes 0x01.
- R9: A read of address 5 returns 0x60 OR line status bit 0. Writes to addresses 2, 5 and 6 change no readable state.
- R10: A read of address 6 always returns 0xB0.
- R11: A read of address 7 returns the bitwise inverse of the last byte written there.
- R12: Addresses 1 (interrupt enable), 3 (line control) and 4 (modem control) read back exactly the last byte written.
- R13: When a receive byte is accepted in the same cycle that a read of address 0 or 2 is taken, the read returns the state from before the load. The load, including its identification update, is applied after the read's clearing.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cpu_req | input | 1 | Access request, held until `cpu_ack` |
| cpu_we | input | 1 | 1 = write, 0 = read |
| cpu_addr | input | 3 | Register address |
| cpu_wdata | input | DW | Write byte |
| cpu_ack | output | 1 | One-cycle completion pulse |
| cpu_rdata | output | DW | Read byte, valid with `cpu_ack` |
| cpu_rd_err | output | 1 | Read of address 0 with no byte held, valid with `cpu_ack` |
| rx_valid | input | 1 | Receive byte offered |
| rx_data | input | DW | Receive byte |
| rx_ready | output | 1 | Receive byte can be taken |
| tx_valid | output | 1 | Transmit byte present |
| tx_data | output | DW | Transmit byte |
| tx_ready | input | 1 | Transmit byte accepted |
| irq | output | 1 | Interrupt request |

## Verification
A receive load and a processor read of the data or identification register can land on the same clock edge. This happens because `rx_ready` is high whenever the holding byte is empty. The bench provokes it directly by raising `rx_valid` in the same cycle a read request is presented, and it also leaves it to chance under random traffic. Its reference model judges the outcome by applying the read's clearing first and then the load. It then checks the returned byte, the error flag, the following identification reads and `irq` against that ordering.

// File: rtl/srf_pkg.sv
package srf_pkg;
  localparam int ADDR_W = 3;

  localparam logic [ADDR_W-1:0] A_DATA = 3'd0;
  localparam logic [ADDR_W-1:0] A_IEN  = 3'd1;
  localparam logic [ADDR_W-1:0] A_IDENT = 3'd2;
  localparam logic [ADDR_W-1:0] A_LCTL = 3'd3;
  localparam logic [ADDR_W-1:0] A_MCTL = 3'd4;
  localparam logic [ADDR_W-1:0] A_LSTAT = 3'd5;
  localparam logic [ADDR_W-1:0] A_MSTAT = 3'd6;
  localparam logic [ADDR_W-1:0] A_SCRATCH = 3'd7;

  // identification cause bits
  localparam int ID_IDLE = 0;
  localparam int ID_TX   = 1;
  localparam int ID_RX   = 2;

  // fixed status patterns
  localparam logic [7:0] LSTAT_FIXED = 8'h60;
  localparam logic [7:0] MSTAT_FIXED = 8'hB0;

  typedef enum logic {ST_IDLE, ST_TXWAIT} cpu_st_t;
endpackage

// File: rtl/srf_rx_hold.sv
module srf_rx_hold #(
  parameter int DW = 8
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          in_valid,
  input  logic [DW-1:0] in_data,
  input  logic          take,
  output logic          in_ready,
  output logic          load,
  output logic          full_q,
  output logic [DW-1:0] byte_q
);
  assign in_ready = ~full_q;
  assign load     = in_valid & ~full_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      full_q <= 1'b0;
      byte_q <= '0;
    end else begin
      if (take && full_q) begin
        full_q <= 1'b0;
        byte_q <= '0;
      end
      if (load) begin
        full_q <= 1'b1;
        byte_q <= in_data;
      end
    end
  end

  // R4: a held byte survives until the processor takes it
  p_hold_r4: assert property (@(posedge clk) disable iff (rst)
    full_q && !take |=> full_q && $stable(byte_q));
  // R3: an offered byte with room is captured
  p_capture_r3: assert property (@(posedge clk) disable iff (rst)
    in_valid && in_ready |=> full_q && byte_q == $past(in_data));
endmodule

// File: rtl/srf_ident.sv
module srf_ident #(
  parameter int DW = 8
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          rd_data,
  input  logic          rd_ident,
  input  logic          rx_set,
  input  logic          tx_set,
  output logic [DW-1:0] ident_q
);
  import srf_pkg::*;

  logic [DW-1:0] ident_n;

  always_comb begin
    ident_n = ident_q;
    if (rd_data)  ident_n[ID_RX] = 1'b0;
    if (rd_ident) ident_n[ID_TX] = 1'b0;
    if ((rd_data || rd_ident) && ident_n == '0) ident_n[ID_IDLE] = 1'b1;
    if (rx_set) begin
      ident_n[ID_RX]   = 1'b1;
      ident_n[ID_IDLE] = 1'b0;
    end
    if (tx_set) begin
      ident_n[ID_TX]   = 1'b1;
      ident_n[ID_IDLE] = 1'b0;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) ident_q <= DW'(1);
    else     ident_q <= ident_n;
  end

  // R8: a cause bit set always implies pending is flagged
  p_pending_r8: assert property (@(posedge clk) disable iff (rst)
    (ident_q[ID_TX] || ident_q[ID_RX]) |-> !ident_q[ID_IDLE]);
  // R6: a data read without a concurrent load drops the receive cause
  p_rxclr_r6: assert property (@(posedge clk) disable iff (rst)
    rd_data && !rx_set |=> !ident_q[ID_RX]);
  // R7: an identification read without a concurrent transfer drops the transmit cause
  p_txclr_r7: assert property (@(posedge clk) disable iff (rst)
    rd_ident && !tx_set |=> !ident_q[ID_TX]);
endmodule

// File: rtl/srf_tx_slot.sv
module srf_tx_slot #(
  parameter int DW = 8
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          start,
  input  logic [DW-1:0] start_data,
  input  logic          out_ready,
  output logic          out_valid,
  output logic [DW-1:0] out_data,
  output logic          done
);
  assign done = out_valid & out_ready;

  always_ff @(posedge clk) begin
    if (rst) begin
      out_valid <= 1'b0;
      out_data  <= '0;
    end else if (start) begin
      out_valid <= 1'b1;
      out_data  <= start_data;
    end else if (done) begin
      out_valid <= 1'b0;
    end
  end

  // R5: a stalled byte stays on the stream unchanged
  p_stall_r5: assert property (@(posedge clk) disable iff (rst)
    out_valid && !out_ready |=> out_valid && $stable(out_data));
endmodule

// File: rtl/serial_regfile.sv
module serial_regfile #(
  parameter int DW = 8
) (
  input  logic                   clk,
  input  logic                   rst,
  input  logic                   cpu_req,
  input  logic                   cpu_we,
  input  logic [srf_pkg::ADDR_W-1:0] cpu_addr,
  input  logic [DW-1:0]          cpu_wdata,
  output logic                   cpu_ack,
  output logic [DW-1:0]          cpu_rdata,
  output logic                   cpu_rd_err,
  input  logic                   rx_valid,
  input  logic [DW-1:0]          rx_data,
  output logic                   rx_ready,
  output logic                   tx_valid,
  output logic [DW-1:0]          tx_data,
  input  logic                   tx_ready,
  output logic                   irq
);
  import srf_pkg::*;

  cpu_st_t       st_q;
  logic [DW-1:0] ien_q, lctl_q, mctl_q, scr_q;
  logic [DW-1:0] ident_q, held_q, rd_mux;
  logic          full_q, rx_load, tx_done;
  logic          go, rd_go, rd_data, rd_ident, tx_start;

  assign go       = cpu_req && !cpu_ack && (st_q == ST_IDLE);
  assign rd_go    = go && !cpu_we;
  assign rd_data  = rd_go && (cpu_addr == A_DATA);
  assign rd_ident = rd_go && (cpu_addr == A_IDENT);
  assign tx_start = go && cpu_we && (cpu_addr == A_DATA);

  srf_rx_hold #(.DW(DW)) u_rx (
    .clk(clk), .rst(rst), .in_valid(rx_valid), .in_data(rx_data),
    .take(rd_data), .in_ready(rx_ready), .load(rx_load),
    .full_q(full_q), .byte_q(held_q)
  );

  srf_ident #(.DW(DW)) u_id (
    .clk(clk), .rst(rst), .rd_data(rd_data), .rd_ident(rd_ident),
    .rx_set(rx_load && ien_q[0]), .tx_set(tx_done && ien_q[1]),
    .ident_q(ident_q)
  );

  srf_tx_slot #(.DW(DW)) u_tx (
    .clk(clk), .rst(rst), .start(tx_start), .start_data(cpu_wdata),
    .out_ready(tx_ready), .out_valid(tx_valid), .out_data(tx_data),
    .done(tx_done)
  );

  always_comb begin
    case (cpu_addr)
      A_DATA:  rd_mux = held_q;
      A_IEN:   rd_mux = ien_q;
      A_IDENT: rd_mux = ident_q;
      A_LCTL:  rd_mux = lctl_q;
      A_MCTL:  rd_mux = mctl_q;
      A_LSTAT: rd_mux = DW'(LSTAT_FIXED) | DW'(full_q);
      A_MSTAT: rd_mux = DW'(MSTAT_FIXED);
      default: rd_mux = ~scr_q;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      st_q       <= ST_IDLE;
      cpu_ack    <= 1'b0;
      cpu_rdata  <= '0;
      cpu_rd_err <= 1'b0;
      ien_q      <= '0;
      lctl_q     <= '0;
      mctl_q     <= '0;
      scr_q      <= '0;
    end else begin
      cpu_ack    <= 1'b0;
      cpu_rd_err <= 1'b0;
      case (st_q)
        ST_IDLE: if (go) begin
          if (tx_start) begin
            st_q <= ST_TXWAIT;
          end else begin
            cpu_ack <= 1'b1;
            if (!cpu_we) begin
              cpu_rdata  <= rd_mux;
              cpu_rd_err <= rd_data && !full_q;
            end else begin
              case (cpu_addr)
                A_IEN:     ien_q  <= cpu_wdata;
                A_LCTL:    lctl_q <= cpu_wdata;
                A_MCTL:    mctl_q <= cpu_wdata;
                A_SCRATCH: scr_q  <= cpu_wdata;
                default:   ;
              endcase
            end
          end
        end
        default: if (tx_done) begin
          cpu_ack <= 1'b1;
          st_q    <= ST_IDLE;
        end
      endcase
    end
  end

  assign irq = ~ident_q[0];

  // R5: no acknowledge while the transmit byte is stalled
  p_noack_stall_r5: assert property (@(posedge clk) disable iff (rst)
    tx_valid && !tx_ready |=> !cpu_ack);
  // R12: acknowledge is a single-cycle pulse
  p_ack_pulse_r12: assert property (@(posedge clk) disable iff (rst)
    cpu_ack |=> !cpu_ack);
  // R6: error flag only accompanies an acknowledge
  p_err_ack_r6: assert property (@(posedge clk) disable iff (rst)
    cpu_rd_err |-> cpu_ack);
endmodule

// File: tb/tb_serial_regfile.sv
module tb_serial_regfile;
  localparam int DW = 8;

  logic clk = 1'b0, rst = 1'b1;
  logic cpu_req = 1'b0, cpu_we = 1'b0;
  logic [2:0] cpu_addr = '0;
  logic [DW-1:0] cpu_wdata = '0;
  logic cpu_ack, cpu_rd_err;
  logic [DW-1:0] cpu_rdata;
  logic rx_valid = 1'b0;
  logic [DW-1:0] rx_data = '0;
  logic rx_ready, tx_valid, irq;
  logic [DW-1:0] tx_data;
  logic tx_ready = 1'b1;

  always #2.5 clk = ~clk;

  serial_regfile #(.DW(DW)) dut (
    .clk(clk), .rst(rst), .cpu_req(cpu_req), .cpu_we(cpu_we),
    .cpu_addr(cpu_addr), .cpu_wdata(cpu_wdata), .cpu_ack(cpu_ack),
    .cpu_rdata(cpu_rdata), .cpu_rd_err(cpu_rd_err), .rx_valid(rx_valid),
    .rx_data(rx_data), .rx_ready(rx_ready), .tx_valid(tx_valid),
    .tx_data(tx_data), .tx_ready(tx_ready), .irq(irq)
  );

  int checks = 0, errors = 0;
  bit finished = 0;

  // reference model
  logic [7:0] m_data = 0, m_ien = 0, m_id = 8'h01, m_lctl = 0, m_mctl = 0, m_scr = 0;
  logic m_full = 0;
  bit model_on = 0, rx_rand = 0, rx_seen = 0;
  int tx_mode = 0, tx_cnt = 0, exp_tx = 0;
  logic [7:0] last_tx = 0;

  task automatic chk(input bit ok, input string tg, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual=0x%0h expected=0x%0h at %0t", tg, act, exp, $time);
    end
  endtask

  function automatic logic [7:0] exp_rd(input logic [2:0] a);
    case (a)
      3'd0: return m_data;
      3'd1: return m_ien;
      3'd2: return m_id;
      3'd3: return m_lctl;
      3'd4: return m_mctl;
      3'd5: return 8'h60 | {7'd0, m_full};
      3'd6: return 8'hB0;
      default: return ~m_scr;
    endcase
  endfunction

  function automatic string tag_of(input logic [2:0] a);
    case (a)
      3'd0: return "R6";
      3'd2: return "R7";
      3'd5: return "R9";
      3'd6: return "R10";
      3'd7: return "R11";
      default: return "R12";
    endcase
  endfunction

  always @(negedge clk) begin
    if (model_on) begin
      bit acc;
      acc = rx_valid && rx_seen;
      if (cpu_ack) begin
        if (!cpu_we) begin
          logic [7:0] e;
          string tg;
          e = exp_rd(cpu_addr);
          tg = (acc && (cpu_addr == 3'd0 || cpu_addr == 3'd2)) ? "R13" : tag_of(cpu_addr);
          chk(cpu_rdata == e, tg, cpu_rdata, e);
          if (cpu_addr == 3'd0) begin
            chk(cpu_rd_err == !m_full, "R6", cpu_rd_err, !m_full);
            if (m_full) begin m_data = 0; m_full = 0; end
            m_id[2] = 1'b0;
            if (m_id == 0) m_id = 8'h01; // R8
          end else if (cpu_addr == 3'd2) begin
            m_id[1] = 1'b0;
            if (m_id == 0) m_id = 8'h01; // R8
          end
        end else begin
          case (cpu_addr)
            3'd0: begin
              exp_tx++;
              chk(tx_cnt == exp_tx, "R5", tx_cnt, exp_tx);
              chk(last_tx == cpu_wdata, "R5", last_tx, cpu_wdata);
              if (m_ien[1]) begin m_id[1] = 1'b1; m_id[0] = 1'b0; end
            end
            3'd1: m_ien = cpu_wdata;
            3'd3: m_lctl = cpu_wdata;
            3'd4: m_mctl = cpu_wdata;
            3'd7: m_scr = cpu_wdata;
            default: ;
          endcase
        end
      end
      if (acc) begin // R3
        m_data = rx_data;
        m_full = 1'b1;
        if (m_ien[0]) begin m_id[2] = 1'b1; m_id[0] = 1'b0; end
        rx_valid = 1'b0;
      end
      chk(irq == !m_id[0], "R2", irq, !m_id[0]);
      chk(rx_ready == !m_full, "R4", rx_ready, !m_full);
      // drive phase for the coming edge
      tx_ready = (tx_mode == 0) ? 1'b1 : (tx_mode == 2) ? 1'b0 : 1'($urandom);
      if (tx_valid && tx_ready) begin tx_cnt++; last_tx = tx_data; end
      if (rx_rand && !rx_valid && ($urandom % 3 == 0)) begin
        rx_valid = 1'b1;
        rx_data = 8'($urandom);
      end
      rx_seen = rx_ready;
    end
  end

  task automatic cpu_op(input bit we, input logic [2:0] a, input logic [7:0] d);
    @(negedge clk); #1;
    cpu_req = 1'b1; cpu_we = we; cpu_addr = a; cpu_wdata = d;
    do begin @(negedge clk); #1; end while (!cpu_ack);
    cpu_req = 1'b0;
  endtask

  // read presented in the same cycle as a receive byte (R13)
  task automatic cpu_rd_with_rx(input logic [2:0] a, input logic [7:0] b);
    @(negedge clk); #1;
    cpu_req = 1'b1; cpu_we = 1'b0; cpu_addr = a;
    rx_valid = 1'b1; rx_data = b; rx_seen = rx_ready;
    do begin @(negedge clk); #1; end while (!cpu_ack);
    cpu_req = 1'b0;
  endtask

  task automatic read_all();
    for (int a = 0; a < 8; a++) cpu_op(1'b0, 3'(a), 8'h00);
  endtask

  task automatic finish_run();
    if (!finished) begin
      finished = 1;
      $display("  Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    checks++; errors++;
    $display("FAIL watchdog: actual=hung expected=done");
    finish_run();
  end

  initial begin
    void'($urandom(32'h5EED1234));
    repeat (4) @(posedge clk);
    @(negedge clk); rst = 1'b0;
    @(negedge clk); #1;
    // R1 reset state at the ports
    chk(irq == 1'b0, "R1", irq, 0);
    chk(rx_ready == 1'b1, "R1", rx_ready, 1);
    chk(tx_valid == 1'b0, "R1", tx_valid, 0);
    chk(cpu_ack == 1'b0, "R1", cpu_ack, 0);
    model_on = 1;
    read_all(); // R1 register values via model, incl. R10/R11

    // R12 / R11 readback
    cpu_op(1, 3'd3, 8'hA5); cpu_op(1, 3'd4, 8'h3C); cpu_op(1, 3'd7, 8'h0F);
    read_all();
    // R9 ignored writes
    cpu_op(1, 3'd5, 8'hFF); cpu_op(1, 3'd6, 8'hFF); cpu_op(1, 3'd2, 8'hC7);
    read_all();

    // R6 empty data read
    cpu_op(0, 3'd0, 0);
    // R3/R4 hold: enable rx interrupt, load two bytes back to back
    cpu_op(1, 3'd1, 8'h01);
    @(negedge clk); #1; rx_valid = 1'b1; rx_data = 8'h11; rx_seen = rx_ready;
    repeat (2) @(negedge clk);
    #1; rx_valid = 1'b1; rx_data = 8'h22; rx_seen = rx_ready;
    repeat (6) @(negedge clk);
    chk(rx_valid == 1'b1, "R4", rx_valid, 1);
    cpu_op(0, 3'd2, 0);       // expects 0x04
    cpu_op(0, 3'd0, 0);       // 0x11, 0x22 then loads
    repeat (3) @(negedge clk);
    cpu_op(0, 3'd0, 0);       // 0x22
    cpu_op(0, 3'd2, 0);       // back to 0x01 (R8)

    // R13: data read on empty with same-cycle load, then identification read with load
    cpu_rd_with_rx(3'd0, 8'hC3);
    cpu_op(0, 3'd0, 0);
    cpu_rd_with_rx(3'd2, 8'h5A);
    cpu_op(0, 3'd2, 0);
    cpu_op(0, 3'd0, 0);

    // R5 transmit stall and interrupt
    cpu_op(1, 3'd1, 8'h02);
    tx_mode = 2;
    fork
      cpu_op(1, 3'd0, 8'h9E);
      begin
        repeat (3) @(negedge clk);
        for (int i = 0; i < 6; i++) begin
          @(negedge clk); #1;
          chk(cpu_ack == 1'b0 && tx_valid == 1'b1, "R5", {cpu_ack, tx_valid}, 1);
        end
        tx_mode = 0;
      end
    join
    cpu_op(0, 3'd2, 0); // 0x02 then cleared
    cpu_op(0, 3'd2, 0); // 0x01

    // random traffic
    rx_rand = 1; tx_mode = 1;
    for (int n = 0; n < 1500; n++) begin
      logic [2:0] a;
      a = 3'($urandom);
      if ($urandom % 2) cpu_op(1'b1, a, 8'($urandom));
      else cpu_op(1'b0, a, 8'h00);
    end
    rx_rand = 0;
    repeat (4) @(negedge clk);
    finish_run();
  end
endmodule